// File: doc/BRIEF.md
# Register-Immediate Integer ALU Executor

This unit executes the basic integer arithmetic and logic group of a 32-bit, three-operand RISC instruction format. Each accepted instruction word comes with the values of its two source registers, already read from an external register file. The unit decodes the word and picks operand two, either the second register or a sign-extended 13-bit immediate. It then computes one of eight operations and registers the destination index, the result, a write enable and an illegal-instruction flag. It also keeps the four integer condition codes (negative, zero, overflow, carry). A word may update these codes only if its code-update bit is set.

Words from other opcode groups are still accepted and produce an output beat. That beat carries neither a write enable nor the illegal flag, so a neighbouring execution unit can take the word. Register 0 reads as zero and is never written. An OR whose first source is register 0 acts as a move of operand two.

Input and output are valid/ready streams with a single output register. `in_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, every output field holds and no new word is taken. The condition codes change on the clock edge that accepts the word, and they appear on `cc_nzvc` together with that word's output beat.

Top module: `alu_ri_exec`

## Requirements
- R1: A word belongs to the group only when bits 31:30 are 2'b10 and op3 (bits 24:19) has bits 5 and 3 both zero. Any other word still yields out_valid, with out_wen=0, out_illegal=0, out_result=0, out_cc_update=0 and the codes unchanged.
- R2: When bit 13 is 1, operand two is bits 12:0 sign-extended to DATA_W. When bit 13 is 0, operand two is the rs2 value, where rs2 is the index in bits 4:0.
- R3: op3 bits 2:0 select the operation: 0 add, 1 and, 2 or, 3 xor, 4 sub (rs1 minus op2), 5 rs1 and not op2, 6 rs1 or not op2, 7 not (rs1 xor op2). The result appears on out_result for in-group legal words. rd is taken from bits 29:25 and rs1 from bits 18:14.
- R4: When op3 bit 4 (word bit 23) is set, a legal in-group word updates cc_nzvc (bit 3 N, bit 2 Z, bit 1 V, bit 0 C) and raises out_cc_update. When op3 bit 4 is clear, cc_nzvc is unchanged.
- R5: A register-form word (bit 13 = 0) with any nonzero bit in 12:5 raises out_illegal. It gives out_wen=0 and out_result=0, and it leaves the codes unchanged.
- R6: Register index 0 reads as zero for both sources. An rd of 0 gives out_wen=0, but a code update still takes place.
- R7: An OR whose rs1 is 0 returns operand two unchanged. This covers a register copy, an immediate load, and a clear when rs2 is 0.
- R8: Logic-class code updates (op3 bits 2:0 other than 0 and 4) set N to the result MSB and Z to (result == 0), and clear V and C.
- R9: For add, C is the carry out and V is signed overflow. For sub, C is the unsigned borrow (rs1 < op2) and V is signed overflow.
- R10: in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, every output holds its value.
- R11: A synchronous active-high reset clears out_valid and cc_nzvc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction beat offered |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_word | input | 32 | Instruction word |
| in_rs1_val | input | DATA_W | Register file value for the rs1 index |
| in_rs2_val | input | DATA_W | Register file value for the rs2 index |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_rd | output | 5 | Destination register index |
| out_result | output | DATA_W | Operation result |
| out_wen | output | 1 | Write the result to out_rd |
| out_illegal | output | 1 | Malformed register-form word |
| out_cc_update | output | 1 | This beat changed the condition codes |
| cc_nzvc | output | 4 | Current condition codes N, Z, V, C |

## Verification
The bench checks the add and subtract corners where flags are most often wrong. These are signed overflow at both signed limits, carry out of an all-ones add, and the borrow of 0 minus 1. A design with a swapped borrow sense or the wrong overflow formula would report wrong C or V exactly there.

Further cases are stray bits in the unused field of a register-form word, the all-ones 13-bit immediate, and words whose op3 bit 3 is set. A design that ignored the stray bits would write a register. A design that did not sign-extend would produce a small positive operand. A design that decoded too loosely would claim a foreign word.

Still other cases are rd of 0 with a code update, the move alias with rs2 of 0, a plain operation after a code-updating one, and a stalled output. Here a broken design would write register 0, skip the flag update, clobber the held codes, or change a beat while the consumer is stalled.

// File: rtl/alu_ri_pkg.sv
package alu_ri_pkg;
  localparam int IMM_W  = 13;
  localparam int IDX_W  = 5;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_AND  = 3'd1,
    OP_OR   = 3'd2,
    OP_XOR  = 3'd3,
    OP_SUB  = 3'd4,
    OP_ANDN = 3'd5,
    OP_ORN  = 3'd6,
    OP_XNOR = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    CC_NONE  = 2'd0,
    CC_LOGIC = 2'd1,
    CC_ADD   = 2'd2,
    CC_SUB   = 2'd3
  } cc_class_e;
endpackage

// File: rtl/alu_ri_decode.sv
module alu_ri_decode
  import alu_ri_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              in_group,
  output logic              illegal,
  output logic              use_imm,
  output logic              upd_cc,
  output alu_op_e           op,
  output cc_class_e         cc_cls,
  output logic [IDX_W-1:0]  rd,
  output logic [IDX_W-1:0]  rs1,
  output logic [IDX_W-1:0]  rs2,
  output logic [IMM_W-1:0]  simm
);
  logic [1:0] major;
  logic [5:0] op3;
  logic       stray;

  always_comb begin
    major    = word[31:30];
    op3      = word[24:19];
    rd       = word[29:25];
    rs1      = word[18:14];
    use_imm  = word[13];
    simm     = word[12:0];
    rs2      = word[4:0];
    in_group = (major == 2'b10) && !op3[5] && !op3[3];
    stray    = !use_imm && (word[12:5] != 8'd0);
    illegal  = in_group && stray;
    upd_cc   = op3[4];
    op       = alu_op_e'(op3[2:0]);
    if (!in_group || illegal || !upd_cc) begin
      cc_cls = CC_NONE;
    end else begin
      unique case (op)
        OP_ADD:  cc_cls = CC_ADD;
        OP_SUB:  cc_cls = CC_SUB;
        default: cc_cls = CC_LOGIC;
      endcase
    end
  end
endmodule

// File: rtl/alu_ri_core.sv
module alu_ri_core
  import alu_ri_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e             op,
  input  logic                use_imm,
  input  logic                upd_cc,
  input  logic [IDX_W-1:0]    rs1,
  input  logic [IDX_W-1:0]    rs2,
  input  logic [IMM_W-1:0]    simm,
  input  logic [DATA_W-1:0]   rs1_val,
  input  logic [DATA_W-1:0]   rs2_val,
  output logic [DATA_W-1:0]   result,
  output logic                a_msb,
  output logic                b_msb,
  output logic                carry,
  output logic                borrow
);
  logic [DATA_W-1:0] opa, reg_b, imm_x, opb;
  logic [DATA_W:0]   sum_w, diff_w;

  generate
    if (DATA_W > IMM_W) begin : g_sext
      assign imm_x = {{(DATA_W-IMM_W){simm[IMM_W-1]}}, simm};
    end else begin : g_trunc
      assign imm_x = simm[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    opa    = (rs1 == '0) ? '0 : rs1_val;
    reg_b  = (rs2 == '0) ? '0 : rs2_val;
    opb    = use_imm ? imm_x : reg_b;
    sum_w  = {1'b0, opa} + {1'b0, opb};
    diff_w = {1'b0, opa} - {1'b0, opb};
    carry  = sum_w[DATA_W];
    borrow = diff_w[DATA_W];
    a_msb  = opa[DATA_W-1];
    b_msb  = opb[DATA_W-1];
    unique case (op)
      OP_ADD:  result = sum_w[DATA_W-1:0];
      OP_AND:  result = opa & opb;
      OP_OR:   result = (!upd_cc && rs1 == '0) ? opb : (opa | opb);
      OP_XOR:  result = opa ^ opb;
      OP_SUB:  result = diff_w[DATA_W-1:0];
      OP_ANDN: result = opa & ~opb;
      OP_ORN:  result = opa | ~opb;
      default: result = ~(opa ^ opb);
    endcase
  end
endmodule

// File: rtl/alu_ri_flags.sv
module alu_ri_flags
  import alu_ri_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cc_class_e           cls,
  input  logic [DATA_W-1:0]   result,
  input  logic                a_msb,
  input  logic                b_msb,
  input  logic                carry,
  input  logic                borrow,
  output logic [3:0]          nzvc
);
  logic n, z, r_msb;

  always_comb begin
    r_msb = result[DATA_W-1];
    n     = r_msb;
    z     = (result == '0);
    unique case (cls)
      CC_ADD:  nzvc = {n, z, (a_msb == b_msb) && (r_msb != a_msb), carry};
      CC_SUB:  nzvc = {n, z, (a_msb != b_msb) && (r_msb != a_msb), borrow};
      default: nzvc = {n, z, 2'b00};
    endcase
  end
endmodule

// File: rtl/alu_ri_exec.sv
module alu_ri_exec
  import alu_ri_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  input  logic [DATA_W-1:0] in_rs1_val,
  input  logic [DATA_W-1:0] in_rs2_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [4:0]        out_rd,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wen,
  output logic              out_illegal,
  output logic              out_cc_update,
  output logic [3:0]        cc_nzvc
);
  logic             d_in_group, d_illegal, d_use_imm, d_upd_cc;
  alu_op_e          d_op;
  cc_class_e        d_cls;
  logic [IDX_W-1:0] d_rd, d_rs1, d_rs2;
  logic [IMM_W-1:0] d_simm;
  logic [DATA_W-1:0] c_result;
  logic             c_amsb, c_bmsb, c_carry, c_borrow;
  logic [3:0]       f_nzvc;
  logic             accept, legal;

  alu_ri_decode u_dec (
    .word(in_word), .in_group(d_in_group), .illegal(d_illegal),
    .use_imm(d_use_imm), .upd_cc(d_upd_cc), .op(d_op), .cc_cls(d_cls),
    .rd(d_rd), .rs1(d_rs1), .rs2(d_rs2), .simm(d_simm)
  );

  alu_ri_core #(.DATA_W(DATA_W)) u_core (
    .op(d_op), .use_imm(d_use_imm), .upd_cc(d_upd_cc), .rs1(d_rs1),
    .rs2(d_rs2), .simm(d_simm), .rs1_val(in_rs1_val), .rs2_val(in_rs2_val),
    .result(c_result), .a_msb(c_amsb), .b_msb(c_bmsb),
    .carry(c_carry), .borrow(c_borrow)
  );

  alu_ri_flags #(.DATA_W(DATA_W)) u_flags (
    .cls(d_cls), .result(c_result), .a_msb(c_amsb), .b_msb(c_bmsb),
    .carry(c_carry), .borrow(c_borrow), .nzvc(f_nzvc)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign legal    = d_in_group && !d_illegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cc_nzvc   <= 4'd0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        if (d_cls != CC_NONE) cc_nzvc <= f_nzvc;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_rd        <= d_rd;
      out_result    <= legal ? c_result : '0;
      out_wen       <= legal && (d_rd != '0);
      out_illegal   <= d_illegal;
      out_cc_update <= (d_cls != CC_NONE);
    end
  end
endmodule

// File: rtl/alu_ri_exec_chk.sv
module alu_ri_exec_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [4:0]        out_rd,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wen,
  input logic              out_illegal,
  input logic [3:0]        cc_nzvc
);
  logic              acc, grp, clean;
  logic [DATA_W-1:0] sx;
  assign acc   = in_valid && in_ready;
  assign grp   = (in_word[31:30] == 2'b10) && !in_word[24] && !in_word[22];
  assign clean = in_word[13] || (in_word[12:5] == 8'd0);
  assign sx    = DATA_W'($signed(in_word[12:0]));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_rd)
      && $stable(out_wen) && $stable(out_illegal));

  // R5
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> !out_wen);

  // R6
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_rd == 5'd0) |-> !out_wen);

  // R4
  cc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc && !in_word[23] |=> $stable(cc_nzvc));

  // R8
  logic_vc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    acc && grp && clean && in_word[23] && (in_word[20:19] != 2'b00)
      |=> cc_nzvc[1:0] == 2'b00);

  // R7
  move_alias_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (in_word[31:30] == 2'b10) && (in_word[24:19] == 6'b000010)
      && (in_word[18:14] == 5'd0) && in_word[13]
      |=> out_result == $past(sx) && out_rd == $past(in_word[29:25]));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && cc_nzvc == 4'd0);
endmodule

bind alu_ri_exec alu_ri_exec_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_rd(out_rd), .out_result(out_result), .out_wen(out_wen),
  .out_illegal(out_illegal), .cc_nzvc(cc_nzvc)
);

// File: tb/test_alu_ri_exec.sv
module test_alu_ri_exec;
  localparam int W = 32;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_word = '0;
  logic [W-1:0] in_rs1_val = '0, in_rs2_val = '0;
  logic in_ready, out_valid, out_wen, out_illegal, out_cc_update;
  logic [4:0] out_rd;
  logic [W-1:0] out_result;
  logic [3:0] cc_nzvc;
  int checks = 0, errors = 0;
  logic [3:0] m_cc = 4'd0;
  bit done = 0;

  always #4 clk = ~clk;

  alu_ri_exec #(.DATA_W(W)) i_alu_ri_exec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_rs1_val(in_rs1_val), .in_rs2_val(in_rs2_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_rd(out_rd),
    .out_result(out_result), .out_wen(out_wen), .out_illegal(out_illegal),
    .out_cc_update(out_cc_update), .cc_nzvc(cc_nzvc)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [5:0] op3, logic [4:0] rd, logic [4:0] rs1,
                                     logic imm, logic [12:0] low);
    return {2'b10, rd, op3, rs1, imm, low};
  endfunction

  function automatic void model(input logic [31:0] w, input logic [W-1:0] av, bv,
                                input logic [3:0] cc_in,
                                output logic [W-1:0] e_res, output logic e_wen,
                                output logic e_ill, output logic e_upd,
                                output logic [3:0] e_cc);
    logic grp, ill, im;
    logic [W-1:0] a, b, r;
    logic [W:0] s;
    grp = (w[31:30] == 2'b10) && !w[24] && !w[22];
    im  = w[13];
    ill = grp && !im && (w[12:5] != 0);
    a = (w[18:14] == 0) ? '0 : av;
    b = im ? {{(W-13){w[12]}}, w[12:0]} : ((w[4:0] == 0) ? '0 : bv);
    case (w[21:19])
      3'd0: r = a + b;
      3'd1: r = a & b;
      3'd2: r = a | b;
      3'd3: r = a ^ b;
      3'd4: r = a - b;
      3'd5: r = a & ~b;
      3'd6: r = a | ~b;
      default: r = ~(a ^ b);
    endcase
    e_cc = cc_in;
    e_upd = grp && !ill && w[23];
    if (e_upd) begin
      if (w[21:19] == 3'd0) begin
        s = {1'b0, a} + {1'b0, b};
        e_cc = {r[W-1], r == 0, (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]), s[W]};
      end else if (w[21:19] == 3'd4) begin
        e_cc = {r[W-1], r == 0, (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]), a < b};
      end else begin
        e_cc = {r[W-1], r == 0, 2'b00};
      end
    end
    e_res = (grp && !ill) ? r : '0;
    e_wen = grp && !ill && (w[29:25] != 0);
    e_ill = ill;
  endfunction

  task automatic issue(string req, logic [31:0] w, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] er; logic ew, ei, eu; logic [3:0] ec;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_rs1_val = a; in_rs2_val = b;
    model(w, a, b, m_cc, er, ew, ei, eu, ec);
    @(negedge clk);
    in_valid = 1'b0;
    m_cc = ec;
    check(req, "out_valid", out_valid, 1);
    check(req, "out_rd", out_rd, w[29:25]);
    check(req, "out_result", out_result, er);
    check(req, "out_wen", out_wen, ew);
    check(req, "out_illegal", out_illegal, ei);
    check(req, "out_cc_update", out_cc_update, eu);
    check(req, "cc_nzvc", cc_nzvc, ec);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [W-1:0] a, b, ra;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "out_valid", out_valid, 0);
    check("R11", "cc_nzvc", cc_nzvc, 0);
    check("R10", "in_ready", in_ready, 1);
    rst = 1'b0;

    // R9 add overflow, carry
    issue("R9", mk(6'b010000, 5'd3, 5'd1, 0, 13'd2), 32'h7fffffff, 32'h1);
    issue("R9", mk(6'b010000, 5'd3, 5'd1, 0, 13'd2), 32'hffffffff, 32'h1);
    issue("R9", mk(6'b010100, 5'd3, 5'd1, 0, 13'd2), 32'h0, 32'h1);
    issue("R9", mk(6'b010100, 5'd3, 5'd1, 1, 13'd1), 32'h80000000, 32'h0);
    // R4 plain op keeps codes
    issue("R4", mk(6'b000000, 5'd4, 5'd1, 1, 13'd5), 32'h10, 32'h0);
    // R2 all-ones immediate sign-extends
    issue("R2", mk(6'b000001, 5'd4, 5'd1, 1, 13'h1fff), 32'hdeadbeef, 32'h0);
    issue("R2", mk(6'b000000, 5'd4, 5'd1, 1, 13'h1000), 32'h0, 32'h0);
    // R3 complemented logic
    issue("R3", mk(6'b000101, 5'd5, 5'd2, 0, 13'd7), 32'hff00ff00, 32'h0ff00ff0);
    issue("R3", mk(6'b000110, 5'd5, 5'd2, 0, 13'd7), 32'h00000000, 32'h0000ffff);
    issue("R8", mk(6'b010111, 5'd5, 5'd2, 0, 13'd7), 32'h12345678, 32'h12345678);
    // R5 stray bits
    issue("R5", mk(6'b010000, 5'd6, 5'd2, 0, 13'h0027), 32'h5, 32'h5);
    issue("R5", mk(6'b000010, 5'd6, 5'd2, 0, 13'h1000), 32'h5, 32'h5);
    // R6 rd zero, codes still updated; rs1 zero reads as zero
    issue("R6", mk(6'b010100, 5'd0, 5'd7, 0, 13'd8), 32'h3, 32'h3);
    issue("R6", mk(6'b000000, 5'd9, 5'd0, 0, 13'd8), 32'hffff, 32'h22);
    // R7 move alias
    issue("R7", mk(6'b000010, 5'd10, 5'd0, 0, 13'd5), 32'h99, 32'hcafef00d);
    issue("R7", mk(6'b000010, 5'd10, 5'd0, 0, 13'd0), 32'h99, 32'hcafef00d);
    issue("R7", mk(6'b000010, 5'd10, 5'd0, 1, 13'h1ff0), 32'h99, 32'h0);
    // R1 foreign words
    issue("R1", {2'b11, 5'd3, 6'b010000, 5'd1, 1'b1, 13'd1}, 32'h1, 32'h1);
    issue("R1", mk(6'b011000, 5'd3, 5'd1, 1, 13'd1), 32'h1, 32'h1);
    issue("R1", mk(6'b100010, 5'd3, 5'd1, 1, 13'd1), 32'h1, 32'h1);

    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_word = mk(6'b000000, 5'd11, 5'd1, 1, 13'd1);
    in_rs1_val = 32'd100; in_rs2_val = 0;
    @(negedge clk);
    check("R10", "result A", out_result, 101);
    check("R10", "in_ready stalled", in_ready, 0);
    in_word = mk(6'b000100, 5'd12, 5'd1, 1, 13'd1);
    @(negedge clk);
    check("R10", "held result", out_result, 101);
    check("R10", "held rd", out_rd, 11);
    check("R10", "held valid", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "result B", out_result, 99);
    check("R10", "rd B", out_rd, 12);
    @(negedge clk);
    check("R10", "drained", out_valid, 0);

    // random mix (R3)
    for (int i = 0; i < 600; i++) begin
      logic [5:0] op3;
      logic im;
      logic [12:0] low;
      op3 = {1'b0, 1'($urandom), 1'b0, 3'($urandom)};
      im = 1'($urandom);
      low = 13'($urandom);
      if (!im) low[12:5] = (($urandom % 8) == 0) ? 8'($urandom) : 8'd0;
      w = mk(op3, 5'($urandom), (($urandom % 6) == 0) ? 5'd0 : 5'($urandom), im, low);
      if (($urandom % 8) == 0) w = $urandom;
      ra = $urandom;
      case ($urandom % 5)
        0: a = 32'h7fffffff; 1: a = 32'h80000000; 2: a = 32'hffffffff;
        default: a = ra;
      endcase
      b = (($urandom % 4) == 0) ? a : $urandom;
      issue("R3", w, a, b);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule